// File: doc/BRIEF.md
# Character Display RAM Power-On Clear Sequencer

This block brings a character-display controller into a known state after power-up. An active-low clear input is brought into the dot-clock domain through a two-flop synchronizer. While the clear is held, the block forces the controller's configuration registers to their default values. These are the per-row character size, the two output distribution bits, display enable, oscillator enable, test mode and the write pointer. It also reports busy and closes the command gate.

When the clear is released, the block walks through every cell of the character video RAM. It goes column by column within a row, then on to the next row. Each cell gets the blank code with its blink attribute cleared. One cell takes a fixed number of dot clocks, and the single write strobe is issued in the last of those clocks. When the final cell has been written, a one-cycle done pulse appears, busy drops and commands are accepted again.

The walk advances only on dot clock edges, so a missing dot clock leaves the block busy. Asserting the clear again during a walk restarts the walk from the first cell.

Top module: `poc_seq_top`

## Requirements
- R1: The clear input passes through two synchronizer flops. From the third dot clock after the clear goes low, and for as long as it stays low, busy is 1, cmd_ok is 0 and ram_we is 0.
- R2: While clear is active, row_size becomes all zeros (single size on every row), dist_sel becomes 2'b00, disp_en becomes 0, osc_en becomes 1 and test_en becomes 0.
- R3: While clear is active, the write pointer outputs wp_row and wp_col become 0.
- R4: After release, exactly ROWS×COLS write strobes are issued. Strobe k addresses row k/COLS and column k%COLS, so the column advances first and the row advances at the end of each row.
- R5: Every strobe carries ram_code = 8'hFE (8'h7E when NARROW=1) and ram_blink = 0.
- R6: Write strobes are single-cycle and exactly CELL_CLKS dot clocks apart. The first strobe is visible after the (CELL_CLKS+3)th dot clock edge following release: two synchronizer edges, one arming edge, then CELL_CLKS.
- R7: done is a single-cycle pulse. It comes in the same cycle as the strobe for row ROWS-1, column COLS-1. busy falls to 0 and cmd_ok rises to 1 in that same cycle.
- R8: cmd_ok is 0 throughout the clear and the whole walk, and it is never 1 together with busy.
- R9: Asserting the clear during a walk aborts it. After the next release the walk starts again at row 0, column 0 with the full latency of R6.
- R10: With no dot clock edges the walk stalls. Busy and all outputs hold, and the walk resumes where it stopped once edges return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| clr_n | input | 1 | Asynchronous active-low power-on clear |
| ram_we | output | 1 | Video RAM write strobe |
| ram_row | output | RW | Row address of the write |
| ram_col | output | CW | Column address of the write |
| ram_code | output | 8 | Character code written (blank code) |
| ram_blink | output | 1 | Blink attribute written (always 0) |
| busy | output | 1 | Clear or RAM walk in progress |
| done | output | 1 | One-cycle pulse at the end of the walk |
| cmd_ok | output | 1 | Command-accept gate for the decoder |
| wp_row | output | RW | Default RAM write pointer row |
| wp_col | output | CW | Default RAM write pointer column |
| row_size | output | ROWS | Per-row double-size flags (0 = single) |
| dist_sel | output | 2 | Output distribution select |
| disp_en | output | 1 | Display enable |
| osc_en | output | 1 | Oscillator enable |
| test_en | output | 1 | Test mode select |

## Verification
Uninterrupted walks after clear pulses of random length show the strobe cadence, the address order, the blank payload and the placement of done. They separate an off-by-one in the tick or column counters from a correct sequence. Aborts at random points, and directed aborts on the first strobe and one cycle before done, show whether a restart really returns to cell 0 and not to wherever the counters stopped. Stopping the dot clock mid-walk shows that nothing advances without edges, while idle cycles after done confirm that the block stays quiet and the command gate stays open.

// File: rtl/poc_pkg.sv
package poc_pkg;
  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_ARM  = 2'd1,
    WK_RUN  = 2'd2
  } walk_st_e;

  localparam logic [7:0] CODE_BLANK_WIDE   = 8'hFE;
  localparam logic [7:0] CODE_BLANK_NARROW = 8'h7E;

  function automatic logic [7:0] blank_code(input bit narrow);
    return narrow ? CODE_BLANK_NARROW : CODE_BLANK_WIDE;
  endfunction
endpackage

// File: rtl/poc_clr_sync.sv
module poc_clr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n_in,
  output logic clr_act
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    chain_q <= {chain_q[STAGES-2:0], clr_n_in};
  end

  assign clr_act = ~chain_q[STAGES-1];
endmodule

// File: rtl/poc_cell_walker.sv
module poc_cell_walker
  import poc_pkg::*;
#(
  parameter int ROWS      = 12,
  parameter int COLS      = 24,
  parameter int CELL_CLKS = 12,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int TW = (CELL_CLKS > 1) ? $clog2(CELL_CLKS) : 1
) (
  input  logic          clk,
  input  logic          clr_act,
  output logic          fire,
  output logic          fire_last,
  output logic          active,
  output logic [RW-1:0] cur_row,
  output logic [CW-1:0] cur_col
);
  localparam logic [RW-1:0] LAST_ROW  = RW'(ROWS - 1);
  localparam logic [CW-1:0] LAST_COL  = CW'(COLS - 1);
  localparam logic [TW-1:0] LAST_TICK = TW'(CELL_CLKS - 1);

  walk_st_e      st_q;
  logic [TW-1:0] tick_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;

  always_ff @(posedge clk) begin
    if (clr_act) begin
      st_q   <= WK_ARM;
      tick_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      case (st_q)
        WK_ARM: begin
          st_q   <= WK_RUN;
          tick_q <= '0;
        end
        WK_RUN: begin
          if (tick_q == LAST_TICK) begin
            tick_q <= '0;
            if (col_q == LAST_COL) begin
              col_q <= '0;
              if (row_q == LAST_ROW) begin
                row_q <= '0;
                st_q  <= WK_IDLE;
              end else begin
                row_q <= row_q + 1'b1;
              end
            end else begin
              col_q <= col_q + 1'b1;
            end
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  assign fire      = (st_q == WK_RUN) && (tick_q == LAST_TICK);
  assign fire_last = fire && (row_q == LAST_ROW) && (col_q == LAST_COL);
  assign active    = (st_q != WK_IDLE);
  assign cur_row   = row_q;
  assign cur_col   = col_q;
endmodule

// File: rtl/poc_default_regs.sv
module poc_default_regs #(
  parameter int ROWS = 12,
  parameter int COLS = 24,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic            clk,
  input  logic            clr_act,
  output logic [RW-1:0]   wp_row,
  output logic [CW-1:0]   wp_col,
  output logic [ROWS-1:0] row_size,
  output logic [1:0]      dist_sel,
  output logic            disp_en,
  output logic            osc_en,
  output logic            test_en
);
  genvar g;
  generate
    for (g = 0; g < ROWS; g++) begin : g_row_size
      always_ff @(posedge clk) begin
        if (clr_act) row_size[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clr_act) begin
      wp_row   <= '0;
      wp_col   <= '0;
      dist_sel <= 2'b00;
      disp_en  <= 1'b0;
      osc_en   <= 1'b1;
      test_en  <= 1'b0;
    end
  end
endmodule

// File: rtl/poc_seq_top.sv
module poc_seq_top
  import poc_pkg::*;
#(
  parameter int ROWS      = 12,
  parameter int COLS      = 24,
  parameter int CELL_CLKS = 12,
  parameter bit NARROW    = 1'b0,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic            clk,
  input  logic            clr_n,
  output logic            ram_we,
  output logic [RW-1:0]   ram_row,
  output logic [CW-1:0]   ram_col,
  output logic [7:0]      ram_code,
  output logic            ram_blink,
  output logic            busy,
  output logic            done,
  output logic            cmd_ok,
  output logic [RW-1:0]   wp_row,
  output logic [CW-1:0]   wp_col,
  output logic [ROWS-1:0] row_size,
  output logic [1:0]      dist_sel,
  output logic            disp_en,
  output logic            osc_en,
  output logic            test_en
);
  localparam logic [7:0] BLANK = blank_code(NARROW);

  logic          clr_act;
  logic          fire, fire_last, active;
  logic [RW-1:0] cur_row;
  logic [CW-1:0] cur_col;

  poc_clr_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .clr_n_in (clr_n),
    .clr_act  (clr_act)
  );

  poc_cell_walker #(.ROWS(ROWS), .COLS(COLS), .CELL_CLKS(CELL_CLKS)) u_walk (
    .clk       (clk),
    .clr_act   (clr_act),
    .fire      (fire),
    .fire_last (fire_last),
    .active    (active),
    .cur_row   (cur_row),
    .cur_col   (cur_col)
  );

  poc_default_regs #(.ROWS(ROWS), .COLS(COLS)) u_regs (
    .clk      (clk),
    .clr_act  (clr_act),
    .wp_row   (wp_row),
    .wp_col   (wp_col),
    .row_size (row_size),
    .dist_sel (dist_sel),
    .disp_en  (disp_en),
    .osc_en   (osc_en),
    .test_en  (test_en)
  );

  always_ff @(posedge clk) begin
    ram_we    <= fire & ~clr_act;
    ram_row   <= cur_row;
    ram_col   <= cur_col;
    ram_code  <= BLANK;
    ram_blink <= 1'b0;
    done      <= fire_last & ~clr_act;
    busy      <= clr_act | (active & ~fire_last);
    cmd_ok    <= ~clr_act & (~active | fire_last);
  end
endmodule

// File: rtl/poc_seq_chk.sv
module poc_seq_chk #(
  parameter int ROWS      = 12,
  parameter int COLS      = 24,
  parameter int CELL_CLKS = 12,
  parameter bit NARROW    = 1'b0,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int GW = $clog2(CELL_CLKS + 2)
) (
  input logic          clk,
  input logic          clr_act,
  input logic          ram_we,
  input logic [RW-1:0] ram_row,
  input logic [CW-1:0] ram_col,
  input logic [7:0]    ram_code,
  input logic          ram_blink,
  input logic          busy,
  input logic          done,
  input logic          cmd_ok
);
  localparam logic [7:0] BLANK = NARROW ? 8'h7E : 8'hFE;

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (clr_act) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (ram_we) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != GW'(CELL_CLKS + 1)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R8
  a_r8_gate_vs_busy: assert property (@(posedge clk) disable iff (clr_act)
    cmd_ok |-> !busy);
  // R5
  a_r5_blank_payload: assert property (@(posedge clk) disable iff (clr_act)
    ram_we |-> (ram_code == BLANK) && !ram_blink);
  // R4
  a_r4_addr_range: assert property (@(posedge clk) disable iff (clr_act)
    ram_we |-> (ram_row < RW'(ROWS)) && (ram_col < CW'(COLS)));
  // R7
  a_r7_done_on_last: assert property (@(posedge clk) disable iff (clr_act)
    done |-> ram_we && (ram_row == RW'(ROWS - 1)) && (ram_col == CW'(COLS - 1)));
  // R7
  a_r7_done_single: assert property (@(posedge clk) disable iff (clr_act)
    done |=> !done);
  // R7
  a_r7_busy_drops: assert property (@(posedge clk) disable iff (clr_act)
    done |-> !busy && cmd_ok);
  // R6
  a_r6_strobe_spacing: assert property (@(posedge clk) disable iff (clr_act)
    (ram_we && seen_q) |-> (gap_q == GW'(CELL_CLKS - 1)));
endmodule

bind poc_seq_top poc_seq_chk #(
  .ROWS(ROWS), .COLS(COLS), .CELL_CLKS(CELL_CLKS), .NARROW(NARROW)
) u_chk (
  .clk       (clk),
  .clr_act   (clr_act),
  .ram_we    (ram_we),
  .ram_row   (ram_row),
  .ram_col   (ram_col),
  .ram_code  (ram_code),
  .ram_blink (ram_blink),
  .busy      (busy),
  .done      (done),
  .cmd_ok    (cmd_ok)
);

// File: tb/poc_seq_top_tb.sv
module poc_seq_top_tb;
  localparam int ROWS = 12, COLS = 24, CELL_CLKS = 12;
  localparam int RW = $clog2(ROWS), CW = $clog2(COLS);
  localparam int CELLS = ROWS * COLS;
  localparam int FIRST = CELL_CLKS + 3;
  localparam int LAST_IT = FIRST + CELL_CLKS * (CELLS - 1);

  logic clk = 1'b0, clk_run = 1'b1, clr_n = 1'b0;
  logic ram_we, ram_blink, busy, done, cmd_ok, disp_en, osc_en, test_en;
  logic [RW-1:0] ram_row, wp_row;
  logic [CW-1:0] ram_col, wp_col;
  logic [7:0] ram_code;
  logic [ROWS-1:0] row_size;
  logic [1:0] dist_sel;
  int vectors = 0, fails = 0;
  bit finished = 0;

  always begin
    #10;
    if (clk_run) clk = ~clk;
  end

  poc_seq_top #(.ROWS(ROWS), .COLS(COLS), .CELL_CLKS(CELL_CLKS)) u_dut (
    .clk(clk), .clr_n(clr_n), .ram_we(ram_we), .ram_row(ram_row), .ram_col(ram_col),
    .ram_code(ram_code), .ram_blink(ram_blink), .busy(busy), .done(done), .cmd_ok(cmd_ok),
    .wp_row(wp_row), .wp_col(wp_col), .row_size(row_size), .dist_sel(dist_sel),
    .disp_en(disp_en), .osc_en(osc_en), .test_en(test_en));

  function automatic bit exp_we(int it);
    return (it >= FIRST) && ((it - FIRST) % CELL_CLKS == 0) && ((it - FIRST) / CELL_CLKS < CELLS);
  endfunction
  function automatic int exp_cell(int it);
    return (it - FIRST) / CELL_CLKS;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_clear(int len);
    clr_n = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        chk(busy == 1'b1, "R1 busy", int'(busy), 1);
        chk(cmd_ok == 1'b0, "R1 cmd_ok", int'(cmd_ok), 0);
        chk(ram_we == 1'b0, "R1 ram_we", int'(ram_we), 0);
        chk(row_size == '0, "R2 row_size", int'(row_size), 0);
        chk(dist_sel == 2'b00, "R2 dist_sel", int'(dist_sel), 0);
        chk(disp_en == 1'b0, "R2 disp_en", int'(disp_en), 0);
        chk(osc_en == 1'b1, "R2 osc_en", int'(osc_en), 1);
        chk(test_en == 1'b0, "R2 test_en", int'(test_en), 0);
        chk(wp_row == '0 && wp_col == '0, "R3 write pointer", int'({wp_row, wp_col}), 0);
      end
    end
    clr_n = 1'b1;
  endtask

  // abort_at < 0: no abort; stall_at < 0: no stall
  task automatic walk(int abort_at, int stall_at, int stall_cyc);
    for (int it = 1; it <= LAST_IT + 4; it++) begin
      @(negedge clk);
      if (it == abort_at) return;
      if (it == stall_at) begin
        automatic logic b0 = busy, w0 = ram_we;
        clk_run = 1'b0;
        #(stall_cyc * 20 - 5);
        chk(busy == b0 && busy == 1'b1, "R10 busy held in stall", int'(busy), 1);
        chk(ram_we == w0, "R10 strobe frozen", int'(ram_we), int'(w0));
        #5;
        clk_run = 1'b1;
      end
      chk(ram_we == exp_we(it), "R6 strobe timing", int'(ram_we), int'(exp_we(it)));
      if (exp_we(it)) begin
        chk(int'(ram_row) == exp_cell(it) / COLS, "R4 row order", int'(ram_row), exp_cell(it) / COLS);
        chk(int'(ram_col) == exp_cell(it) % COLS, "R4 column order", int'(ram_col), exp_cell(it) % COLS);
        chk(ram_code == 8'hFE, "R5 blank code", int'(ram_code), 254);
        chk(ram_blink == 1'b0, "R5 blink off", int'(ram_blink), 0);
      end
      chk(done == (it == LAST_IT), "R7 done pulse", int'(done), int'(it == LAST_IT));
      chk(busy == (it < LAST_IT), "R7 busy", int'(busy), int'(it < LAST_IT));
      chk(cmd_ok == (it >= LAST_IT), "R8 cmd_ok gate", int'(cmd_ok), int'(it >= LAST_IT));
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0c1));
    // reset state and first full walk
    do_clear(6);
    walk(-1, -1, 0);
    // R9: directed abort on first strobe, then one cycle before done
    do_clear(4);
    walk(FIRST, -1, 0);
    do_clear(5);
    walk(LAST_IT - 1, -1, 0);
    do_clear(5);
    walk(-1, -1, 0);
    // R10 and R9 with random points
    for (int k = 0; k < 2; k++) begin
      do_clear(4 + int'($urandom_range(0, 8)));
      walk(int'($urandom_range(20, LAST_IT - 20)), -1, 0);
      do_clear(4 + int'($urandom_range(0, 8)));
      walk(-1, int'($urandom_range(5, LAST_IT - 5)), int'($urandom_range(3, 40)));
    end
    // idle after done: quiet and gate open
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(ram_we == 1'b0 && done == 1'b0, "R7 idle quiet", int'({ram_we, done}), 0);
      chk(cmd_ok == 1'b1 && busy == 1'b0, "R8 idle gate", int'({cmd_ok, busy}), 2);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule